// File: doc/BRIEF.md
# SPI Ready-Marker Hunting Receiver

This block is the host side of a mode-0 SPI link to a peripheral that signals flow control on its data-out line. Until it is ready, the peripheral holds POCI low, so the host sees words filled with zeros. The host asserts chip select and clocks whole words without pause. It throws away every word until one arrives whose last bit is a 1. That marker word says the peripheral is ready. The word after the marker is the first real data word, and from there the block passes the requested number of words to a valid/ready stream.

Word length is 16 or 32 bits and is captured when a transfer starts. The marker search behaves the same whether the host is reading or writing. The block gives up with an error if the marker has not appeared after a chosen number of words. The number of words skipped before the marker is reported, and two status flags show whether the block is still hunting or already streaming.

Top module: `spi_ready_hunter`

## Requirements
- R1: While reset is asserted, and after it, cs_no is 1, sclk_o is 0, rx_valid_o is 0, hunting_o and streaming_o are 0, and timeout_err_o is 0.
- R2: When idle, a start_i pulse pulls cs_no low. SCLK then idles low and runs with a period of 2*HALF_PER clock cycles. POCI is sampled on each rising SCLK edge, most significant bit first. A start_i pulse while a transfer is running is ignored.
- R3: While hunting, any word whose final (last-sampled) bit is 0 is discarded, never appears on the output stream, and adds one to skipped_o. This includes all-zero words.
- R4: The marker word, whose final bit is 1, is not delivered. The word that follows it is the first word delivered.
- R5: With wide_i=0 a word is 16 bits, delivered in rx_data_o[15:0] with bits 31:16 zero. With wide_i=1 a word is 32 bits.
- R6: wide_i is captured at start. Changing it during a transfer has no effect on word boundaries.
- R7: Exactly data_words_i data words are delivered. After the last one, SCLK returns low and cs_no goes high. SCLK is never high while cs_no is high.
- R8: If timeout_words_i words in a row (at least 1) end in 0 while hunting, the transfer stops. timeout_err_o goes to 1, cs_no is released, and no data is delivered. The error flag clears on the next start.
- R9: rx_data_o stays stable while rx_valid_o=1 and rx_ready_i=0. SCLK pauses at the next word boundary until the word has been taken, so no word is lost.
- R10: hunting_o is 1 while the marker is being sought. streaming_o is 1 during the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| wide_i | input | 1 | Word size select: 0 = 16 bits, 1 = 32 bits |
| data_words_i | input | CNT_W | Number of data words to deliver |
| timeout_words_i | input | CNT_W | Non-marker word limit while hunting |
| poci_i | input | 1 | Serial data from peripheral |
| sclk_o | output | 1 | SPI clock, mode 0 |
| cs_no | output | 1 | Chip select, active low |
| rx_data_o | output | DATA_W | Received data word |
| rx_valid_o | output | 1 | Data word valid |
| rx_ready_i | input | 1 | Consumer ready |
| hunting_o | output | 1 | Seeking ready marker |
| streaming_o | output | 1 | Delivering data words |
| skipped_o | output | CNT_W | Words skipped before marker |
| timeout_err_o | output | 1 | Marker search timed out |

## Verification
The marker search is tried with several busy prefixes: none, a short run of zero words, and a prefix that includes a non-zero word ending in 0. These separate a check on the final bit from a check for an all-zero word. An all-zero word placed after the marker must still be delivered, which shows the discard applies only before the marker. Trailing words placed beyond the requested count must never be delivered. A stream that never ends in 1 must trip the timeout. A long consumer stall must freeze both the data and SCLK, which shows words are neither lost nor overwritten.

// File: rtl/spi_hunt_pkg.sv
package spi_hunt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HUNT  = 2'd1,
    PH_DATA  = 2'd2,
    PH_DRAIN = 2'd3
  } phase_e;
endpackage

// File: rtl/spi_sck_gen.sv
// Fixed-divider mode-0 SCLK source; rise_o marks the edge where SCLK goes high.
module spi_sck_gen #(
  parameter int HALF_PER = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o
);
  localparam int CW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
  localparam logic [CW-1:0] TERM = CW'(HALF_PER - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          term;

  assign term = (cnt_q == TERM);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (term) begin
      cnt_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = run_i && term && !sclk_q;

  // R2
  sclk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(sclk_o));
endmodule

// File: rtl/spi_word_shift.sv
// Shifts POCI in MSB first and marks each word boundary for the selected size.
module spi_word_shift #(
  parameter int DATA_W  = 32,
  parameter int SHORT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              bit_i,
  input  logic              wide_i,
  output logic              word_done_o,
  output logic              last_bit_o,
  output logic              at_start_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST_WIDE  = BW'(DATA_W - 1);
  localparam logic [BW-1:0] LAST_SHORT = BW'(SHORT_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d, full;
  logic [BW-1:0]     cnt_q, cnt_d, last_idx;

  assign last_idx    = wide_i ? LAST_WIDE : LAST_SHORT;
  assign full        = {sh_q[DATA_W-2:0], bit_i};
  assign word_done_o = sample_i && (cnt_q == last_idx);
  assign last_bit_o  = bit_i;
  assign at_start_o  = (cnt_q == '0);
  assign word_o      = wide_i ? full
                              : {{(DATA_W-SHORT_W){1'b0}}, full[SHORT_W-1:0]};

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clear_i) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (sample_i) begin
      sh_d  = full;
      cnt_d = word_done_o ? '0 : cnt_q + BW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  // R5
  bit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_idx);
endmodule

// File: rtl/spi_ready_hunter.sv
module spi_ready_hunter
  import spi_hunt_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int HALF_PER = 2,
  parameter int DATA_W   = 32,
  parameter int SHORT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wide_i,
  input  logic [CNT_W-1:0]  data_words_i,
  input  logic [CNT_W-1:0]  timeout_words_i,
  input  logic              poci_i,
  output logic              sclk_o,
  output logic              cs_no,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              hunting_o,
  output logic              streaming_o,
  output logic [CNT_W-1:0]  skipped_o,
  output logic              timeout_err_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  phase_e            ph_q, ph_d;
  logic              wide_q, wide_d, err_q, err_d, valid_q, valid_d;
  logic [CNT_W-1:0]  words_q, words_d, limit_q, limit_d;
  logic [CNT_W-1:0]  skip_q, skip_d, dcnt_q, dcnt_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              run, rise, word_done, last_bit, at_start, clear;
  logic [DATA_W-1:0] word;

  spi_sck_gen #(.HALF_PER(HALF_PER)) u_sck (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(run), .sclk_o(sclk_o), .rise_o(rise)
  );

  spi_word_shift #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_n), .clear_i(clear), .sample_i(rise),
    .bit_i(poci_i), .wide_i(wide_q), .word_done_o(word_done),
    .last_bit_o(last_bit), .at_start_o(at_start), .word_o(word)
  );

  assign clear = (ph_q == PH_IDLE) && start_i;

  always_comb begin
    unique case (ph_q)
      PH_HUNT:  run = 1'b1;
      PH_DATA:  run = !(valid_q && at_start && !sclk_o);
      PH_DRAIN: run = sclk_o;
      default:  run = 1'b0;
    endcase
  end

  always_comb begin
    ph_d    = ph_q;
    wide_d  = wide_q;
    words_d = words_q;
    limit_d = limit_q;
    skip_d  = skip_q;
    dcnt_d  = dcnt_q;
    err_d   = err_q;
    data_d  = data_q;
    valid_d = valid_q;
    if (valid_q && rx_ready_i) valid_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        ph_d    = PH_HUNT;
        wide_d  = wide_i;
        words_d = data_words_i;
        limit_d = timeout_words_i;
        skip_d  = '0;
        dcnt_d  = '0;
        err_d   = 1'b0;
      end
      PH_HUNT: if (word_done) begin
        if (last_bit) begin
          ph_d = (words_q == '0) ? PH_DRAIN : PH_DATA;
        end else begin
          skip_d = skip_q + ONE;
          if ((skip_q + ONE) >= limit_q) begin
            err_d = 1'b1;
            ph_d  = PH_DRAIN;
          end
        end
      end
      PH_DATA: if (word_done) begin
        data_d  = word;
        valid_d = 1'b1;
        dcnt_d  = dcnt_q + ONE;
        if ((dcnt_q + ONE) == words_q) ph_d = PH_DRAIN;
      end
      default: if (!sclk_o) ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      wide_q  <= 1'b0;
      words_q <= '0;
      limit_q <= '0;
      skip_q  <= '0;
      dcnt_q  <= '0;
      err_q   <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      wide_q  <= wide_d;
      words_q <= words_d;
      limit_q <= limit_d;
      skip_q  <= skip_d;
      dcnt_q  <= dcnt_d;
      err_q   <= err_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign cs_no         = (ph_q == PH_IDLE);
  assign rx_data_o     = data_q;
  assign rx_valid_o    = valid_q;
  assign hunting_o     = (ph_q == PH_HUNT);
  assign streaming_o   = (ph_q == PH_DATA);
  assign skipped_o     = skip_q;
  assign timeout_err_o = err_q;

  // R7
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    cs_no |-> !sclk_o);
  // R9
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));
  // R9
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (word_done && ph_q == PH_DATA) |-> !valid_q);
  // R4
  hunt_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rx_valid_o) |-> ($past(ph_q) == PH_DATA));
  // R6
  wide_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ph_q != PH_IDLE) |=> $stable(wide_q));
  // R7
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    dcnt_q <= words_q);
endmodule

// File: tb/spi_ready_hunter_bench.sv
module spi_ready_hunter_bench;
  localparam int CLK_PER = 10;
  localparam int HALF    = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, wide_i = 1'b0, rx_ready = 1'b1;
  logic [7:0]  nwords = '0, tlimit = '0;
  logic        poci;
  logic        sclk, cs_n, rx_valid, hunting, streaming, terr;
  logic [31:0] rx_data;
  logic [7:0]  skipped;

  logic [31:0] stream [0:15];
  int          n_stream = 0;
  int          pw = 16;
  int          nr = 0;
  logic [31:0] got [0:63];
  int          n_got = 0;
  int          bad_hunt = 0;
  int          n_chk = 0, n_fail = 0;
  bit          wd_hit = 0;

  always #(CLK_PER/2) clk = !clk;

  spi_ready_hunter u_spi_ready_hunter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .wide_i(wide_i),
    .data_words_i(nwords), .timeout_words_i(tlimit), .poci_i(poci),
    .sclk_o(sclk), .cs_no(cs_n), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .hunting_o(hunting), .streaming_o(streaming),
    .skipped_o(skipped), .timeout_err_o(terr)
  );

  // peripheral model: counts SCLK rises since chip select fell
  initial begin
    forever begin
      @(negedge cs_n);
      nr = 0;
      while (!cs_n) begin
        @(posedge sclk or posedge cs_n);
        if (!cs_n) begin
          #1;
          nr++;
        end
      end
    end
  end

  assign poci = ((nr / pw) < n_stream) ? stream[nr / pw][pw - 1 - (nr % pw)] : 1'b0;

  always @(negedge clk) begin
    if (rx_valid && rx_ready && n_got < 64) begin
      got[n_got] = rx_data;
      n_got++;
    end
    if (rx_valid && hunting) bad_hunt++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic kick(input bit wide, input int words, input int lim);
    pw = wide ? 32 : 16;
    @(negedge clk);
    wide_i  = wide;
    nwords  = 8'(words);
    tlimit  = 8'(lim);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000 && !cs_n; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 reset cs/sclk", {30'd0, cs_n, sclk}, 32'h2);
    chk(rx_valid == 1'b0 && hunting == 1'b0 && streaming == 1'b0 && terr == 1'b0,
        "R1 reset status", {28'd0, rx_valid, hunting, streaming, terr}, 32'h0);
  endtask

  task automatic t_short_words();
    int base;
    time t0, t1;
    base = n_got;
    stream[0] = 32'h0000; stream[1] = 32'h0000; stream[2] = 32'h0001;
    stream[3] = 32'hA5C3; stream[4] = 32'h1234; stream[5] = 32'hFFFE;
    stream[6] = 32'h7777; n_stream = 7;
    kick(1'b0, 3, 10);
    chk(cs_n == 1'b0, "R2 cs asserted", {31'd0, cs_n}, 32'h0);
    wide_i = 1'b1;                    // R6: ignored mid-transfer
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;   // R2: ignored start
    @(posedge sclk); t0 = $time;
    @(posedge sclk); t1 = $time;
    chk((t1 - t0) == 2*HALF*CLK_PER, "R2 sclk period", 32'(t1 - t0), 32'(2*HALF*CLK_PER));
    @(negedge clk);
    chk(hunting == 1'b1 && streaming == 1'b0, "R10 hunting flag", {30'd0, hunting, streaming}, 32'h2);
    for (int k = 0; k < 2000 && !streaming; k++) @(negedge clk);
    chk(streaming == 1'b1 && hunting == 1'b0, "R10 streaming flag", {30'd0, hunting, streaming}, 32'h1);
    wait_idle();
    chk(n_got - base == 3, "R7 word count 16b", 32'(n_got - base), 32'd3);
    chk(got[base] == 32'h0000A5C3, "R4 first word after marker", got[base], 32'h0000A5C3);
    chk(got[base+1] == 32'h00001234, "R5 16b word 2", got[base+1], 32'h00001234);
    chk(got[base+2] == 32'h0000FFFE, "R6 16b word 3 despite wide change", got[base+2], 32'h0000FFFE);
    chk(skipped == 8'd2, "R3 skipped count", {24'd0, skipped}, 32'd2);
    chk(cs_n && !sclk && !terr, "R7 released", {29'd0, cs_n, sclk, terr}, 32'h4);
    chk(bad_hunt == 0, "R3 no data while hunting", 32'(bad_hunt), 32'd0);
  endtask

  task automatic t_long_words();
    int base;
    base = n_got;
    stream[0] = 32'hFFFFFFFE; stream[1] = 32'h00000000; stream[2] = 32'h00000003;
    stream[3] = 32'hDEADBEEF; stream[4] = 32'h00000000; stream[5] = 32'h80000001;
    n_stream = 6;
    kick(1'b1, 3, 10);
    wait_idle();
    chk(n_got - base == 3, "R7 word count 32b", 32'(n_got - base), 32'd3);
    chk(got[base] == 32'hDEADBEEF, "R5 32b word 1", got[base], 32'hDEADBEEF);
    chk(got[base+1] == 32'h0, "R3 zero word after marker is data", got[base+1], 32'h0);
    chk(got[base+2] == 32'h80000001, "R5 32b word 3", got[base+2], 32'h80000001);
    chk(skipped == 8'd2, "R3 nonzero word ending 0 skipped", {24'd0, skipped}, 32'd2);
  endtask

  task automatic t_marker_first();
    int base;
    base = n_got;
    stream[0] = 32'h8001; stream[1] = 32'h0F0F; n_stream = 2;
    kick(1'b0, 1, 4);
    wait_idle();
    chk(n_got - base == 1 && got[base] == 32'h0F0F, "R4 immediate marker", got[base], 32'h0F0F);
    chk(skipped == 8'd0, "R3 no skips", {24'd0, skipped}, 32'd0);
  endtask

  task automatic t_timeout();
    int base;
    base = n_got;
    stream[0] = 32'h0000; stream[1] = 32'h0002; n_stream = 2;
    kick(1'b0, 2, 3);
    wait_idle();
    chk(terr == 1'b1, "R8 timeout error", {31'd0, terr}, 32'd1);
    chk(skipped == 8'd3, "R8 words seen before abort", {24'd0, skipped}, 32'd3);
    chk(n_got == base && cs_n, "R8 no data, cs released", 32'(n_got - base), 32'd0);
    stream[0] = 32'h0001; stream[1] = 32'h4242; n_stream = 2;
    kick(1'b0, 1, 3);
    chk(terr == 1'b0, "R8 error cleared on start", {31'd0, terr}, 32'd0);
    wait_idle();
    chk(n_got - base == 1 && got[base] == 32'h4242, "R8 recovery word", got[base], 32'h4242);
  endtask

  task automatic t_backpressure();
    int base, snap, moved, unstable;
    base = n_got;
    stream[0] = 32'h0001; stream[1] = 32'h1111; stream[2] = 32'h2222;
    stream[3] = 32'h3333; n_stream = 4;
    rx_ready = 1'b0;
    kick(1'b0, 3, 4);
    for (int k = 0; k < 2000 && !rx_valid; k++) @(negedge clk);
    chk(rx_data == 32'h1111, "R9 first held word", rx_data, 32'h1111);
    repeat (10) @(negedge clk);
    snap = nr; moved = 0; unstable = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!rx_valid || rx_data != 32'h1111) unstable++;
      if (sclk) moved++;
    end
    chk(unstable == 0, "R9 data held", 32'(unstable), 32'd0);
    chk(moved == 0 && nr == snap && !cs_n, "R9 sclk paused", 32'(nr - snap), 32'd0);
    rx_ready = 1'b1;
    wait_idle();
    chk(n_got - base == 3, "R9 no word lost", 32'(n_got - base), 32'd3);
    chk(got[base+1] == 32'h2222 && got[base+2] == 32'h3333, "R9 order kept", got[base+2], 32'h3333);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_short_words();
    t_long_words();
    t_marker_first();
    t_timeout();
    t_backpressure();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd_hit = 1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
    end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule